// File: doc/BRIEF.md
# Chained DMA Descriptor Sequencer

This block sits on the endpoint side of a link. It walks a chain of transfer descriptors that software has placed in a table in host memory. Software fills four control dwords, each a 32-bit word. Dword 0 carries the descriptor count and an end-of-chain interrupt enable. Dwords 1 and 2 carry the upper and lower halves of the table base. A write to dword 3 carries the index of the final descriptor and starts the run.

The sequencer fetches one descriptor at a time from the table. A descriptor is four dwords: a length in dwords, the endpoint-side address, and the upper and lower halves of the host-side address. For each descriptor it issues a single transfer command and waits for the transfer engine to report completion. It then records that descriptor's index as the last one completed.

Building packets, moving the payload and sending the message-signalled interrupt are left to neighbouring logic. That logic is reached through simple request, grant, valid and done signals.

Top module: `cdma_chain_seq`

## Requirements
- R1: After reset, `busy`, `fetch_req`, `xfer_req` and `irq_req` are 0, `stat_empty` is 1 and `stat_idx` is all ones.
- R2: A write with `cfg_sel`=3 while idle, with a nonzero count in dword 0 bits [15:0], has these effects one clock later: `busy`=1, `fetch_req`=1, `stat_empty`=0 and `stat_idx` all ones.
- R3: Descriptor n is requested at base + 16 + 16·n. The base is {dword 1, dword 2} with the two lowest bits of dword 2 cleared.
- R4: The four fetched beats are taken in this order: length in beat 0 bits [15:0] (the upper bits are ignored), endpoint address, host upper, host lower. The resulting `xfer_req` is a one-cycle pulse in the cycle after the fourth beat. Both addresses are presented with bits [1:0] cleared, and idle cycles between beats are tolerated.
- R5: Each descriptor in the chain produces exactly one transfer command. No new fetch is requested until `xfer_done` has been seen for the current descriptor, and `fetch_req` and `xfer_req` are never high together.
- R6: `stat_idx` keeps its old value in the cycle after `xfer_done` is sampled. It takes the completed index n in the cycle after that.
- R7: The chain ends after the descriptor whose index equals the stop index. `stat_empty` returns to 1 in the same cycle as the final `stat_idx` update, and `busy` falls one cycle later.
- R8: If the index in dword 3 is greater than or equal to the count, the stop index is count−1.
- R9: When dword 0 bit 16 is set, `irq_req` is a single-cycle pulse in the cycle after the final index update, while `busy` is still 1. When the bit is clear, no pulse appears.
- R10: While `busy` is 1, all control writes are dropped. A write to dword 3 starts nothing, and a base written while busy is not used by later runs.
- R11: A write to dword 3 with a count of zero starts nothing, and `busy` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Control dword write strobe |
| cfg_sel | input | 2 | Control dword select (0 ctrl, 1 base high, 2 base low, 3 last index/start) |
| cfg_wdata | input | 32 | Control write data |
| fetch_req | output | 1 | Descriptor read request, held until granted |
| fetch_addr | output | 64 | Byte address of the descriptor being read |
| fetch_gnt | input | 1 | Read request accepted |
| fetch_vld | input | 1 | Descriptor beat valid |
| fetch_data | input | 32 | Descriptor beat data |
| xfer_req | output | 1 | One-cycle transfer command |
| xfer_len | output | 16 | Transfer length in dwords |
| xfer_ep_addr | output | 32 | Endpoint-side address, dword aligned |
| xfer_host_addr | output | 64 | Host-side address, dword aligned |
| xfer_done | input | 1 | Transfer finished pulse |
| busy | output | 1 | Chain in progress |
| stat_idx | output | 16 | Index of the last completed descriptor (all ones if none) |
| stat_empty | output | 1 | No descriptors pending |
| irq_req | output | 1 | End-of-chain interrupt request pulse |

## Verification
Two control functions can land in the same cycle: software's start write and the completion of the final descriptor. The bench sets this up by driving a dword 3 write on the very edge where the final `xfer_done` is presented. It then adds a base write during the index update and a second start during the interrupt cycle. All of these must be dropped. The proof is that `busy` falls and stays low, the queue of expected transfers drains with nothing extra, and the next run, started without rewriting the base, still fetches from the earlier base.

// File: rtl/cdma_pkg.sv
package cdma_pkg;

   localparam int DWORD_W         = 32;
   localparam int DESC_WORDS      = 4;
   localparam int DESC_BYTES      = 16;
   localparam int TABLE_HDR_BYTES = 16;
   localparam int CTRL_IRQ_BIT    = 16;

   typedef enum logic [1:0] {
      SEL_CTRL    = 2'd0,
      SEL_BASE_HI = 2'd1,
      SEL_BASE_LO = 2'd2,
      SEL_LAST    = 2'd3
   } cfg_sel_e;

   typedef enum logic [2:0] {
      ST_IDLE   = 3'd0,
      ST_FETCH  = 3'd1,
      ST_FILL   = 3'd2,
      ST_ISSUE  = 3'd3,
      ST_WAIT   = 3'd4,
      ST_UPDATE = 3'd5,
      ST_DONE   = 3'd6
   } seq_state_e;

   function automatic logic [DWORD_W-1:0] dw_align(input logic [DWORD_W-1:0] a);
      return {a[DWORD_W-1:2], 2'b00};
   endfunction

endpackage

// File: rtl/cdma_cfg_regs.sv
module cdma_cfg_regs
   import cdma_pkg::*;
#(
   parameter int IDX_W = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [1:0]         wr_sel,
   input  logic [31:0]        wr_data,
   input  logic               lock,
   output logic [IDX_W-1:0]   desc_cnt,
   output logic               end_irq_en,
   output logic [31:0]        base_hi,
   output logic [31:0]        base_lo,
   output logic [IDX_W-1:0]   last_idx,
   output logic               start
);

   generate
      if (IDX_W < 1 || IDX_W > 16) begin : g_bad_idx
         $error("cdma_cfg_regs: IDX_W must lie in 1..16");
      end
   endgenerate

   logic accept;
   logic unused_cfg;

   assign accept     = wr_en && !lock;
   assign start      = accept && (cfg_sel_e'(wr_sel) == SEL_LAST);
   assign unused_cfg = ^wr_data[31:CTRL_IRQ_BIT+1];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         desc_cnt   <= '0;
         end_irq_en <= 1'b0;
         base_hi    <= '0;
         base_lo    <= '0;
         last_idx   <= '0;
      end else if (accept) begin
         case (cfg_sel_e'(wr_sel))
            SEL_CTRL: begin
               desc_cnt   <= wr_data[IDX_W-1:0];
               end_irq_en <= wr_data[CTRL_IRQ_BIT];
            end
            SEL_BASE_HI: base_hi  <= wr_data;
            SEL_BASE_LO: base_lo  <= wr_data;
            default:     last_idx <= wr_data[IDX_W-1:0];
         endcase
      end
   end

endmodule

// File: rtl/cdma_desc_cap.sv
module cdma_desc_cap
   import cdma_pkg::*;
#(
   parameter int LEN_W = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clear,
   input  logic               beat_vld,
   input  logic [31:0]        beat_data,
   output logic               fill_done,
   output logic [LEN_W-1:0]   len,
   output logic [31:0]        ep_addr,
   output logic [31:0]        host_hi,
   output logic [31:0]        host_lo
);

   localparam int BEAT_W = $clog2(DESC_WORDS);

   generate
      if (LEN_W < 1 || LEN_W > DWORD_W) begin : g_bad_len
         $error("cdma_desc_cap: LEN_W must lie in 1..32");
      end
   endgenerate

   logic [BEAT_W-1:0]                  beat;
   logic [DESC_WORDS-1:0][DWORD_W-1:0] words;
   logic                               unused_len;

   always_ff @(posedge clk) begin
      if (!rst_n || clear) begin
         beat <= '0;
      end else if (beat_vld) begin
         beat <= beat + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         words <= '0;
      end else begin
         for (int w = 0; w < DESC_WORDS; w++) begin
            if (beat_vld && beat == BEAT_W'(w)) words[w] <= beat_data;
         end
      end
   end

   assign fill_done = beat_vld && (beat == BEAT_W'(DESC_WORDS - 1));
   assign len       = words[0][LEN_W-1:0];
   assign ep_addr   = words[1];
   assign host_hi   = words[2];
   assign host_lo   = words[3];

   generate
      if (LEN_W < DWORD_W) begin : g_len_rest
         assign unused_len = ^words[0][DWORD_W-1:LEN_W];
      end else begin : g_len_full
         assign unused_len = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/cdma_addr_gen.sv
module cdma_addr_gen
   import cdma_pkg::*;
#(
   parameter int ADDR_W = 64,
   parameter int IDX_W  = 16
) (
   input  logic [31:0]        base_hi,
   input  logic [31:0]        base_lo,
   input  logic [IDX_W-1:0]   idx,
   input  logic [31:0]        host_hi,
   input  logic [31:0]        host_lo,
   output logic [ADDR_W-1:0]  fetch_addr,
   output logic [ADDR_W-1:0]  host_addr
);

   localparam int IDX_SHIFT = $clog2(DESC_BYTES);

   generate
      if (ADDR_W < 32 || ADDR_W > 64) begin : g_bad_addr
         $error("cdma_addr_gen: ADDR_W must lie in 32..64");
      end
   endgenerate

   logic [ADDR_W-1:0] base_full;
   logic [ADDR_W-1:0] offset;

   generate
      if (ADDR_W > 32) begin : g_wide
         logic unused_hi;
         assign base_full = {base_hi[ADDR_W-33:0], dw_align(base_lo)};
         assign host_addr = {host_hi[ADDR_W-33:0], dw_align(host_lo)};
         if (ADDR_W < 64) begin : g_part
            assign unused_hi = ^{base_hi[31:ADDR_W-32], host_hi[31:ADDR_W-32]};
         end else begin : g_full
            assign unused_hi = 1'b0;
         end
      end else begin : g_narrow
         logic unused_hi;
         assign base_full = dw_align(base_lo);
         assign host_addr = dw_align(host_lo);
         assign unused_hi = ^{base_hi, host_hi};
      end
   endgenerate

   assign offset     = ADDR_W'(TABLE_HDR_BYTES) + (ADDR_W'(idx) << IDX_SHIFT);
   assign fetch_addr = base_full + offset;

endmodule

// File: rtl/cdma_chain_seq.sv
module cdma_chain_seq
   import cdma_pkg::*;
#(
   parameter int ADDR_W = 64,
   parameter int IDX_W  = 16,
   parameter int LEN_W  = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cfg_we,
   input  logic [1:0]          cfg_sel,
   input  logic [31:0]         cfg_wdata,
   output logic                fetch_req,
   output logic [ADDR_W-1:0]   fetch_addr,
   input  logic                fetch_gnt,
   input  logic                fetch_vld,
   input  logic [31:0]         fetch_data,
   output logic                xfer_req,
   output logic [LEN_W-1:0]    xfer_len,
   output logic [31:0]         xfer_ep_addr,
   output logic [ADDR_W-1:0]   xfer_host_addr,
   input  logic                xfer_done,
   output logic                busy,
   output logic [IDX_W-1:0]    stat_idx,
   output logic                stat_empty,
   output logic                irq_req
);

   seq_state_e        state;
   logic [IDX_W-1:0]  idx;
   logic [IDX_W-1:0]  desc_cnt;
   logic [IDX_W-1:0]  last_idx;
   logic [IDX_W-1:0]  stop_idx;
   logic [31:0]       base_hi;
   logic [31:0]       base_lo;
   logic [31:0]       ep_raw;
   logic [31:0]       host_hi;
   logic [31:0]       host_lo;
   logic              end_irq_en;
   logic              start;
   logic              go;
   logic              fill_done;

   cdma_cfg_regs #(.IDX_W(IDX_W)) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (cfg_we),
      .wr_sel     (cfg_sel),
      .wr_data    (cfg_wdata),
      .lock       (busy),
      .desc_cnt   (desc_cnt),
      .end_irq_en (end_irq_en),
      .base_hi    (base_hi),
      .base_lo    (base_lo),
      .last_idx   (last_idx),
      .start      (start)
   );

   cdma_desc_cap #(.LEN_W(LEN_W)) u_cap (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear     (state == ST_FETCH && fetch_gnt),
      .beat_vld  (state == ST_FILL && fetch_vld),
      .beat_data (fetch_data),
      .fill_done (fill_done),
      .len       (xfer_len),
      .ep_addr   (ep_raw),
      .host_hi   (host_hi),
      .host_lo   (host_lo)
   );

   cdma_addr_gen #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_addr (
      .base_hi    (base_hi),
      .base_lo    (base_lo),
      .idx        (idx),
      .host_hi    (host_hi),
      .host_lo    (host_lo),
      .fetch_addr (fetch_addr),
      .host_addr  (xfer_host_addr)
   );

   assign stop_idx     = (last_idx >= desc_cnt) ? desc_cnt - 1'b1 : last_idx;
   assign go           = start && (desc_cnt != '0);
   assign xfer_ep_addr = dw_align(ep_raw);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         idx        <= '0;
         stat_idx   <= '1;
         stat_empty <= 1'b1;
      end else begin
         case (state)
            ST_IDLE: begin
               if (go) begin
                  state      <= ST_FETCH;
                  idx        <= '0;
                  stat_idx   <= '1;
                  stat_empty <= 1'b0;
               end
            end
            ST_FETCH:  if (fetch_gnt) state <= ST_FILL;
            ST_FILL:   if (fill_done) state <= ST_ISSUE;
            ST_ISSUE:  state <= ST_WAIT;
            ST_WAIT:   if (xfer_done) state <= ST_UPDATE;
            ST_UPDATE: begin
               stat_idx <= idx;
               if (idx == stop_idx) begin
                  stat_empty <= 1'b1;
                  state      <= ST_DONE;
               end else begin
                  idx   <= idx + 1'b1;
                  state <= ST_FETCH;
               end
            end
            default:   state <= ST_IDLE;
         endcase
      end
   end

   assign busy      = (state != ST_IDLE);
   assign fetch_req = (state == ST_FETCH);
   assign xfer_req  = (state == ST_ISSUE);
   assign irq_req   = (state == ST_DONE) && end_irq_en;

endmodule

// File: rtl/cdma_chain_seq_chk.sv
module cdma_chain_seq_chk #(
   parameter int IDX_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              busy,
   input logic              fetch_req,
   input logic              xfer_req,
   input logic              xfer_done,
   input logic              irq_req,
   input logic              stat_empty,
   input logic [IDX_W-1:0]  stat_idx
);

   // R1
   fetch_when_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_req |-> busy);

   // R4
   xfer_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_req |=> !xfer_req);

   // R5
   req_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(xfer_req && fetch_req));

   // R6
   idx_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_idx != $past(stat_idx)) |-> ($past(xfer_done, 2) || !$past(busy)));

   // R7
   idle_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> stat_empty);

   // R7
   xfer_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_req |-> !stat_empty);

   // R9
   irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |=> !irq_req);

   // R9
   irq_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> (stat_empty && busy));

endmodule

bind cdma_chain_seq cdma_chain_seq_chk #(.IDX_W(IDX_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .busy       (busy),
   .fetch_req  (fetch_req),
   .xfer_req   (xfer_req),
   .xfer_done  (xfer_done),
   .irq_req    (irq_req),
   .stat_empty (stat_empty),
   .stat_idx   (stat_idx)
);

// File: tb/test_cdma_chain_seq.sv
module test_cdma_chain_seq;

   localparam int CLK_PERIOD = 10;
   localparam int ADDR_W     = 64;
   localparam int IDX_W      = 16;
   localparam int LEN_W      = 16;

   typedef struct {
      logic [LEN_W-1:0]  len;
      logic [31:0]       ep;
      logic [ADDR_W-1:0] host;
   } xfer_item_t;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              cfg_we = 1'b0;
   logic [1:0]        cfg_sel = '0;
   logic [31:0]       cfg_wdata = '0;
   logic              fetch_req;
   logic [ADDR_W-1:0] fetch_addr;
   logic              fetch_gnt = 1'b0;
   logic              fetch_vld = 1'b0;
   logic [31:0]       fetch_data = '0;
   logic              xfer_req;
   logic [LEN_W-1:0]  xfer_len;
   logic [31:0]       xfer_ep_addr;
   logic [ADDR_W-1:0] xfer_host_addr;
   logic              xfer_done = 1'b0;
   logic              busy;
   logic [IDX_W-1:0]  stat_idx;
   logic              stat_empty;
   logic              irq_req;

   int                n_chk = 0;
   int                n_fail = 0;
   int                irq_cnt = 0;
   xfer_item_t        exp_q[$];
   logic [31:0]       tbl [0:7][0:3];
   logic [ADDR_W-1:0] exp_base;
   int                exp_stop;
   bit                exp_irq;
   int                cur_k;
   logic [IDX_W-1:0]  prev_idx;
   bit                chain_done;
   bit                fin_drv = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   cdma_chain_seq #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .LEN_W(LEN_W)) i_cdma_chain_seq (
      .clk            (clk),
      .rst_n          (rst_n),
      .cfg_we         (cfg_we),
      .cfg_sel        (cfg_sel),
      .cfg_wdata      (cfg_wdata),
      .fetch_req      (fetch_req),
      .fetch_addr     (fetch_addr),
      .fetch_gnt      (fetch_gnt),
      .fetch_vld      (fetch_vld),
      .fetch_data     (fetch_data),
      .xfer_req       (xfer_req),
      .xfer_len       (xfer_len),
      .xfer_ep_addr   (xfer_ep_addr),
      .xfer_host_addr (xfer_host_addr),
      .xfer_done      (xfer_done),
      .busy           (busy),
      .stat_idx       (stat_idx),
      .stat_empty     (stat_empty),
      .irq_req        (irq_req)
   );

   task automatic chk64(input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
   endtask

   task automatic cfg_write(input logic [1:0] sel, input logic [31:0] data);
      @(negedge clk);
      cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   // host model: serves descriptor reads and completes transfers
   initial begin : responder
      forever begin
         @(negedge clk);
         if (rst_n && fetch_req) begin
            chk64("R3", "descriptor fetch address", fetch_addr,
                  exp_base + 64'd16 + 64'(cur_k) * 64'd16);
            fetch_gnt = 1'b1;
            for (int b = 0; b < 4; b++) begin
               @(negedge clk);
               fetch_gnt = 1'b0;
               if (b == 2 && (cur_k % 2) == 1) begin
                  fetch_vld = 1'b0;
                  @(negedge clk);
               end
               fetch_vld  = 1'b1;
               fetch_data = tbl[cur_k][b];
            end
            @(negedge clk);
            fetch_vld = 1'b0;
            for (int d = 0; d < 1 + (cur_k % 3); d++) begin
               @(negedge clk);
               chk64("R5", "no fetch while transfer pending", 64'(fetch_req), 64'd0);
            end
            xfer_done = 1'b1;
            if (cur_k == exp_stop) fin_drv = 1'b1;
            @(negedge clk);
            xfer_done = 1'b0;
            chk64("R6", "index held one cycle after done", 64'(stat_idx), 64'(prev_idx));
            @(negedge clk);
            chk64("R6", "index updated after done", 64'(stat_idx), 64'(cur_k));
            if (cur_k == exp_stop) begin
               chk64("R7", "empty with final update", 64'(stat_empty), 64'd1);
               chk64("R9", "interrupt pulse at end", 64'(irq_req), 64'(exp_irq));
               @(negedge clk);
               chk64("R9", "interrupt lasts one cycle", 64'(irq_req), 64'd0);
               chk64("R7", "busy falls after final", 64'(busy), 64'd0);
               fin_drv    = 1'b0;
               chain_done = 1'b1;
            end else begin
               chk64("R7", "still pending mid-chain", 64'(stat_empty), 64'd0);
               prev_idx = IDX_W'(cur_k);
               cur_k++;
            end
         end
      end
   end

   // monitor: compares transfer commands with the scoreboard queue
   initial begin : monitor
      xfer_item_t e;
      forever begin
         @(negedge clk);
         if (irq_req) irq_cnt++;
         if (rst_n && xfer_req) begin
            if (exp_q.size() == 0) begin
               chk64("R5", "unexpected transfer command", 64'd1, 64'd0);
            end else begin
               e = exp_q.pop_front();
               chk64("R4", "transfer length", 64'(xfer_len), 64'(e.len));
               chk64("R4", "endpoint address", 64'(xfer_ep_addr), 64'(e.ep));
               chk64("R4", "host address", xfer_host_addr, e.host);
            end
         end
      end
   end

   task automatic busy_writes();
      wait (fin_drv);
      cfg_we = 1'b1; cfg_sel = 2'd3; cfg_wdata = 32'h0000_0000;
      @(negedge clk);
      cfg_sel = 2'd1; cfg_wdata = 32'h0000_DEAD;
      @(negedge clk);
      cfg_sel = 2'd3; cfg_wdata = 32'h0000_0001;
      @(negedge clk);
      cfg_we = 1'b0;
      chk64("R10", "start during final cycles ignored", 64'(busy), 64'd0);
      @(negedge clk);
      chk64("R10", "no run after ignored start", 64'(busy), 64'd0);
   endtask

   task automatic run_chain(input logic [63:0] base, input int cnt, input int last,
                            input bit irqen, input bit wr_base, input bit side);
      int          i0;
      xfer_item_t  e;
      exp_base   = {base[63:2], 2'b00};
      exp_stop   = (last >= cnt) ? cnt - 1 : last;
      exp_irq    = irqen;
      cur_k      = 0;
      prev_idx   = '1;
      chain_done = 1'b0;
      for (int k = 0; k < cnt; k++) begin
         tbl[k][0] = {16'hC3C3 ^ 16'(k), 16'(32 * (k + 1) + cnt)};
         tbl[k][1] = 32'h0010_0000 + 32'(k * 4096) + 32'(k % 4);
         tbl[k][2] = 32'h0000_0007 + 32'(k);
         tbl[k][3] = 32'h4000_0002 + 32'(k * 256);
      end
      for (int k = 0; k <= exp_stop; k++) begin
         e.len  = tbl[k][0][15:0];
         e.ep   = {tbl[k][1][31:2], 2'b00};
         e.host = {tbl[k][2], tbl[k][3][31:2], 2'b00};
         exp_q.push_back(e);
      end
      i0 = irq_cnt;
      cfg_write(2'd0, {15'd0, irqen, 16'(cnt)});
      if (wr_base) begin
         cfg_write(2'd1, base[63:32]);
         cfg_write(2'd2, base[31:0]);
      end
      cfg_write(2'd3, {16'd0, 16'(last)});
      chk64("R2", "busy after start", 64'(busy), 64'd1);
      chk64("R2", "fetch requested after start", 64'(fetch_req), 64'd1);
      chk64("R2", "pending after start", 64'(stat_empty), 64'd0);
      chk64("R2", "index cleared at start", 64'(stat_idx), 64'hFFFF);
      if (!wr_base) chk64("R10", "base unchanged by busy write", fetch_addr, exp_base + 64'd16);
      fork
         begin if (side) busy_writes(); end
         begin wait (chain_done); end
      join
      chk64("R5", "one transfer per descriptor", 64'(exp_q.size()), 64'd0);
      chk64("R9", "interrupt count", 64'(irq_cnt - i0), 64'(irqen));
      if (last >= cnt) chk64("R8", "stop clamped to count-1", 64'(stat_idx), 64'(cnt - 1));
   endtask

   initial begin : watchdog
      repeat (50000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: run did not end, actual=hung expected=done");
      summary();
      $finish;
   end

   initial begin : main
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk64("R1", "busy after reset", 64'(busy), 64'd0);
      chk64("R1", "empty after reset", 64'(stat_empty), 64'd1);
      chk64("R1", "index after reset", 64'(stat_idx), 64'hFFFF);
      chk64("R1", "requests after reset", 64'({fetch_req, xfer_req, irq_req}), 64'd0);

      // misaligned base, three of four descriptors, interrupt on
      run_chain(64'h0000_0001_2000_0003, 4, 2, 1'b1, 1'b1, 1'b0);
      // last index beyond count, interrupt off
      run_chain(64'h0000_0000_0004_0000, 3, 9, 1'b0, 1'b1, 1'b0);

      // zero count: R11
      cfg_write(2'd0, 32'h0001_0000);
      cfg_write(2'd3, 32'h0000_0000);
      chk64("R11", "zero count does not start", 64'(busy), 64'd0);
      repeat (3) @(negedge clk);
      chk64("R11", "zero count stays idle", 64'({busy, fetch_req}), 64'd0);

      // writes collide with the final completion
      run_chain(64'h0000_0002_8000_0000, 2, 1, 1'b1, 1'b1, 1'b1);
      // base not rewritten: must come from previous run
      run_chain(64'h0000_0002_8000_0000, 1, 0, 1'b0, 1'b0, 1'b0);

      repeat (3) @(negedge clk);
      summary();
      $finish;
   end

endmodule